// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from a fast reference clock. Each SCL period is built from three parts: a driven-low phase, a short synchronisation window after the line is released, and a high phase. The lengths of the low and high phases are weights taken from a small ratio table, each multiplied by a programmable divider plus one. The synchronisation window adds a fixed overhead to every period, so one full period lasts (Nlow + Nhigh) × (divider + 1) + overhead reference cycles.

The line is open-drain. The block only pulls SCL low or releases it, and it watches the real line level through a two-flop synchroniser. The high phase starts only once the line is seen high, so a target that holds SCL low stretches the clock. The block gives two one-cycle phase strobes to the bit engine that sits beside it. Falling marks the first cycle SCL is pulled low, and rising marks the first cycle of the high phase. A busy flag is set each time the generator starts from the disabled state, and it stays set until an abort request clears it.

Top module: `scl_clock_gen`

## Requirements
- R1: With the line free, SCL is pulled low for Nlow × (D + 1) cycles. The rising strobe follows SYNC_OVERHEAD (default 4) cycles after the release. The high phase lasts Nhigh × (D + 1) cycles until the next falling strobe. D is the effective divider.
- R2: ratioSel 0 selects Nlow/Nhigh = 4/4, ratioSel 1 selects 6/3, and ratioSel 2 selects 11/6.
- R3: ratioSel 3 behaves exactly like ratioSel 0 (4/4).
- R4: When slaveMode is 1, a divVal of 0 is used as 1. In master mode a divVal of 0 is used as 0. Any non-zero divVal is used unchanged in both modes.
- R5: While the line is held low by another device after release, no rising strobe is given. If the line is released j ≥ 1 cycles after the generator releases it, the rising strobe comes j + 3 cycles after the release.
- R6: ratioSel, divVal and slaveMode are sampled only at the start of a low phase. A change made during a period affects the next period only.
- R7: fallStrobe and riseStrobe are single-cycle pulses and never active together. fallStrobe coincides with the first cycle sclDriveLow is 1. riseStrobe comes while sclDriveLow is 0.
- R8: With enable at 0, the cycle after it is sampled shows SCL released and no strobes. Enabling from the disabled state gives fallStrobe in the first cycle after enable is sampled high.
- R9: busyFlag becomes 1 in the cycle the generator starts from the disabled state. It returns to 0 one cycle after abortCmd is sampled, and it does not clear by disabling.
- R10: After reset, sclDriveLow, riseStrobe, fallStrobe and busyFlag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; 0 releases SCL |
| ratioSel | input | 2 | Low/high weight select (0 4/4, 1 6/3, 2 11/6, 3 as 0) |
| divVal | input | DIV_W (9) | Divider; each weight unit lasts divVal + 1 cycles |
| slaveMode | input | 1 | 1 forces a divider of 0 to 1 |
| sclIn | input | 1 | Sampled SCL line level (asynchronous) |
| abortCmd | input | 1 | Clears busyFlag |
| sclDriveLow | output | 1 | 1 pulls the open-drain SCL line low |
| riseStrobe | output | 1 | One-cycle pulse at the start of the high phase |
| fallStrobe | output | 1 | One-cycle pulse at the start of the low phase |
| busyFlag | output | 1 | Set on start from disabled, cleared by abort |

## Verification
Each ratio select, including the undefined value, is run with small dividers. Measuring low, sync and high lengths separately tells a wrong weight apart from a wrong overhead. A divider of 0 is applied in both modes to separate the slave-mode substitution from master behaviour. A configuration change right after a falling strobe shows whether settings are latched at the period boundary or taken at once. Stretch holds of one and five cycles show that a short hold is hidden by the overhead and that a long one delays the rising strobe. Seeded random ratio/divider/mode mixes and a maximum divider cover the rest of the arithmetic.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  localparam int WEIGHT_W = 4;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_SYNC = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic clrCnt;
    logic incCnt;
  } dpCtrl_t;

  function automatic logic [WEIGHT_W-1:0] lowWeight(input logic [1:0] sel);
    case (sel)
      2'd1:    lowWeight = WEIGHT_W'(6);
      2'd2:    lowWeight = WEIGHT_W'(11);
      default: lowWeight = WEIGHT_W'(4);   // 0 and the undefined 3
    endcase
  endfunction

  function automatic logic [WEIGHT_W-1:0] highWeight(input logic [1:0] sel);
    case (sel)
      2'd1:    highWeight = WEIGHT_W'(3);
      2'd2:    highWeight = WEIGHT_W'(6);
      default: highWeight = WEIGHT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import scl_gen_pkg::*;
#(
  parameter int DIV_W         = 9,
  parameter int SYNC_OVERHEAD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [1:0]       ratioSel,
  input  logic [DIV_W-1:0] divVal,
  input  logic             slaveMode,
  input  logic             sclIn,
  output logic             lowDone,
  output logic             highDone,
  output logic             syncWaitDone,
  output logic             sclSynced
);

  localparam int LEN_W = WEIGHT_W + DIV_W + 1;

  logic [1:0]       syncQ;
  logic [DIV_W-1:0] effDiv;
  logic [LEN_W-1:0] lowLenQ;
  logic [LEN_W-1:0] highLenQ;
  logic [LEN_W-1:0] cntQ;

  // Two-flop synchroniser on the line level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], sclIn};
  end
  assign sclSynced = syncQ[1];

  // Slave mode cannot run with a zero divider
  always_comb begin
    effDiv = divVal;
    if (slaveMode && (divVal == '0)) effDiv = DIV_W'(1);
  end

  // Phase lengths latched at the period boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLenQ  <= '0;
      highLenQ <= '0;
    end else if (ctrl.loadCfg) begin
      lowLenQ  <= LEN_W'(lowWeight(ratioSel))  * (LEN_W'(effDiv) + LEN_W'(1));
      highLenQ <= LEN_W'(highWeight(ratioSel)) * (LEN_W'(effDiv) + LEN_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (ctrl.clrCnt)  cntQ <= '0;
    else if (ctrl.incCnt)  cntQ <= cntQ + LEN_W'(1);
  end

  assign lowDone      = (cntQ == lowLenQ - LEN_W'(1));
  assign highDone     = (cntQ == highLenQ - LEN_W'(1));
  assign syncWaitDone = (cntQ >= LEN_W'(SYNC_OVERHEAD - 1));

endmodule

// File: rtl/scl_gen_control.sv
module scl_gen_control
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    abortCmd,
  input  logic    lowDone,
  input  logic    highDone,
  input  logic    syncWaitDone,
  input  logic    sclSynced,
  output dpCtrl_t ctrl,
  output logic    sclDriveLow,
  output logic    riseStrobe,
  output logic    fallStrobe,
  output logic    busyFlag
);

  phase_t phaseQ, phaseN;
  logic   fallN, riseN, startN;

  always_comb begin
    phaseN = phaseQ;
    ctrl   = '0;
    fallN  = 1'b0;
    riseN  = 1'b0;
    startN = 1'b0;
    if (!enable) begin
      phaseN = PH_OFF;
    end else begin
      case (phaseQ)
        PH_OFF: begin
          phaseN       = PH_LOW;
          ctrl.loadCfg = 1'b1;
          ctrl.clrCnt  = 1'b1;
          fallN        = 1'b1;
          startN       = 1'b1;
        end
        PH_LOW: begin
          if (lowDone) begin
            phaseN      = PH_SYNC;
            ctrl.clrCnt = 1'b1;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
        PH_SYNC: begin
          if (syncWaitDone && sclSynced) begin
            phaseN      = PH_HIGH;
            ctrl.clrCnt = 1'b1;
            riseN       = 1'b1;
          end else if (!syncWaitDone) begin
            ctrl.incCnt = 1'b1;
          end
        end
        default: begin
          if (highDone) begin
            phaseN       = PH_LOW;
            ctrl.loadCfg = 1'b1;
            ctrl.clrCnt  = 1'b1;
            fallN        = 1'b1;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ     <= PH_OFF;
      fallStrobe <= 1'b0;
      riseStrobe <= 1'b0;
      busyFlag   <= 1'b0;
    end else begin
      phaseQ     <= phaseN;
      fallStrobe <= fallN;
      riseStrobe <= riseN;
      if (startN)        busyFlag <= 1'b1;
      else if (abortCmd) busyFlag <= 1'b0;
    end
  end

  assign sclDriveLow = (phaseQ == PH_LOW);

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W         = 9,
  parameter int SYNC_OVERHEAD = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       ratioSel,
  input  logic [DIV_W-1:0] divVal,
  input  logic             slaveMode,
  input  logic             sclIn,
  input  logic             abortCmd,
  output logic             sclDriveLow,
  output logic             riseStrobe,
  output logic             fallStrobe,
  output logic             busyFlag
);

  dpCtrl_t dpCtrl;
  logic    lowDone, highDone, syncWaitDone, sclSynced;

  scl_gen_datapath #(
    .DIV_W        (DIV_W),
    .SYNC_OVERHEAD(SYNC_OVERHEAD)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (dpCtrl),
    .ratioSel    (ratioSel),
    .divVal      (divVal),
    .slaveMode   (slaveMode),
    .sclIn       (sclIn),
    .lowDone     (lowDone),
    .highDone    (highDone),
    .syncWaitDone(syncWaitDone),
    .sclSynced   (sclSynced)
  );

  scl_gen_control uControl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .abortCmd    (abortCmd),
    .lowDone     (lowDone),
    .highDone    (highDone),
    .syncWaitDone(syncWaitDone),
    .sclSynced   (sclSynced),
    .ctrl        (dpCtrl),
    .sclDriveLow (sclDriveLow),
    .riseStrobe  (riseStrobe),
    .fallStrobe  (fallStrobe),
    .busyFlag    (busyFlag)
  );

endmodule

// File: rtl/scl_clock_gen_checker.sv
module scl_clock_gen_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic abortCmd,
  input logic sclDriveLow,
  input logic riseStrobe,
  input logic fallStrobe,
  input logic busyFlag
);

  // R7: falling strobe marks the first driven-low cycle
  a_r7_fall_starts_low: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> (sclDriveLow && !$past(sclDriveLow)));

  // R7: rising strobe only while the line is released
  a_r7_rise_released: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> !sclDriveLow);

  // R7: strobes exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseStrobe, fallStrobe}));

  // R1: release is never the same cycle as the rising strobe
  a_r1_overhead_gap: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclDriveLow) |-> !riseStrobe);

  // R8: disabled generator releases the line and stays quiet
  a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclDriveLow && !riseStrobe && !fallStrobe));

  // R9: abort clears busy
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    (abortCmd && sclDriveLow) |=> !busyFlag);

endmodule

bind scl_clock_gen scl_clock_gen_checker uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .abortCmd   (abortCmd),
  .sclDriveLow(sclDriveLow),
  .riseStrobe (riseStrobe),
  .fallStrobe (fallStrobe),
  .busyFlag   (busyFlag)
);

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

  localparam int DIV_W = 9;
  localparam int OVH   = 4;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN, enable, slaveMode, abortCmd, slaveHold;
  logic [1:0]       ratioSel;
  logic [DIV_W-1:0] divVal;
  logic             sclLine;
  logic             sclDriveLow, riseStrobe, fallStrobe, busyFlag;

  assign sclLine = !sclDriveLow && !slaveHold;

  scl_clock_gen #(.DIV_W(DIV_W), .SYNC_OVERHEAD(OVH)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .ratioSel(ratioSel),
    .divVal(divVal), .slaveMode(slaveMode), .sclIn(sclLine),
    .abortCmd(abortCmd), .sclDriveLow(sclDriveLow), .riseStrobe(riseStrobe),
    .fallStrobe(fallStrobe), .busyFlag(busyFlag)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wLow(input int sel);
    if (sel == 1) return 6;
    if (sel == 2) return 11;
    return 4;
  endfunction

  function automatic int wHigh(input int sel);
    if (sel == 1) return 3;
    if (sel == 2) return 6;
    return 4;
  endfunction

  function automatic int effDivB(input int div, input bit slv);
    return (slv && div == 0) ? 1 : div;
  endfunction

  task automatic setCfg(input int sel, input int div, input bit slv);
    ratioSel  = 2'(sel);
    divVal    = DIV_W'(div);
    slaveMode = slv;
  endtask

  task automatic waitFall(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fallStrobe && n < LIMIT);
    if (n >= LIMIT) check({req, " no falling strobe"}, 0, 1);
  endtask

  // Measure one period; ends at the negedge that shows the next falling strobe
  task automatic measure(input int el, input int eh, input bit startNow, input string req);
    int t = 0, lowT = -1, u = 0, riseAfter = 0;
    if (!startNow) waitFall(req);
    do begin
      @(negedge clk);
      t++;
      if (lowT < 0 && !sclDriveLow) lowT = t;
    end while (!riseStrobe && t < LIMIT);
    check({req, " low length"}, lowT, el);
    check({req, " fall-to-rise"}, t, el + OVH);
    do begin
      @(negedge clk);
      u++;
      if (u == 1) riseAfter = int'(riseStrobe);
    end while (!fallStrobe && u < LIMIT);
    check({req, " R7 rise pulse width"}, riseAfter, 0);
    check({req, " high length"}, u, eh);
  endtask

  // R5: target holds SCL low for hold cycles after release
  task automatic stretch(input int el, input int hold);
    int t = 0;
    waitFall("R5");
    slaveHold = 1'b1;
    while (sclDriveLow && t < LIMIT) begin
      @(negedge clk);
      t++;
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      t++;
      if (riseStrobe) check("R5 rise during hold", 1, 0);
    end
    slaveHold = 1'b0;
    while (!riseStrobe && t < LIMIT) begin
      @(negedge clk);
      t++;
    end
    check("R5 stretched fall-to-rise", t, el + ((hold + 3 > OVH) ? hold + 3 : OVH));
  endtask

  initial begin
    int quiet;
    void'($urandom(32'd20240611));
    rstN = 1'b0; enable = 1'b0; abortCmd = 1'b0; slaveHold = 1'b0;
    setCfg(0, 1, 1'b0);
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 drive", int'(sclDriveLow), 0);
    check("R10 strobes", int'(riseStrobe | fallStrobe), 0);
    check("R10 busy", int'(busyFlag), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8/R9 start from disabled
    enable = 1'b1;
    @(negedge clk);
    check("R8 fall after enable", int'(fallStrobe), 1);
    check("R7 drive with fall", int'(sclDriveLow), 1);
    check("R9 busy on start", int'(busyFlag), 1);
    measure(8, 8, 1'b1, "R1 std div1");

    // R2 ratios, R3 undefined select, R4 divider zero handling
    setCfg(1, 2, 1'b0); measure(18, 9, 1'b0, "R2 asym div2");
    setCfg(2, 0, 1'b0); measure(11, 6, 1'b0, "R2 R4 fast master div0");
    setCfg(3, 3, 1'b0); measure(16, 16, 1'b0, "R3 sel3 div3");
    setCfg(0, 0, 1'b1); measure(8, 8, 1'b0, "R4 slave div0");
    setCfg(1, 5, 1'b1); measure(36, 18, 1'b0, "R4 slave div5");

    // R6 boundary latching
    setCfg(2, 1, 1'b0); measure(22, 12, 1'b0, "R6 prep");
    setCfg(0, 0, 1'b0);
    measure(22, 12, 1'b1, "R6 old config kept");
    measure(4, 4, 1'b1, "R6 new config");

    // R5 stretching
    setCfg(0, 0, 1'b0);
    stretch(4, 5);
    stretch(4, 1);

    // Random mixes
    for (int i = 0; i < 12; i++) begin
      int sel = int'($urandom % 4);
      int div = int'($urandom % 8);
      bit slv = bit'($urandom % 2);
      int d = effDivB(div, slv);
      setCfg(sel, div, slv);
      measure(wLow(sel) * (d + 1), wHigh(sel) * (d + 1), 1'b0, "R1 R2 random");
    end

    // Largest divider
    setCfg(2, 511, 1'b0);
    measure(11 * 512, 6 * 512, 1'b0, "R1 max div");

    // R9 abort
    setCfg(0, 0, 1'b0);
    waitFall("R9");
    abortCmd = 1'b1;
    @(negedge clk);
    abortCmd = 1'b0;
    check("R9 abort clears busy", int'(busyFlag), 0);

    // R8 disable
    enable = 1'b0;
    @(negedge clk);
    check("R8 released after disable", int'(sclDriveLow), 0);
    quiet = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (sclDriveLow || riseStrobe || fallStrobe) quiet++;
    end
    check("R8 quiet while disabled", quiet, 0);
    check("R9 busy stays clear", int'(busyFlag), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R8 restart fall", int'(fallStrobe), 1);
    check("R9 busy on restart", int'(busyFlag), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule